// File: doc/BRIEF.md
# 16x Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line carrying 8N1 frames: one low start bit, eight data bits sent least significant bit first, no parity, and one high stop bit. The line idles high. A strobe input, pulsed for one clock at sixteen times the bit rate, paces all of the timing. It is usually made by dividing the system clock by an integer: for example, a 100 MHz clock at 115200 bits per second gives a divisor of 54. The package exports a function that computes this divisor.

The line first passes through a two-flop synchroniser. In idle, a high-to-low transition on the synchronised line begins a frame. The receiver then counts strobe pulses. On the 8th pulse it checks that the line is still low, which confirms the start bit at its midpoint. Each later sample is taken 16 pulses after the one before. Because the timing base is set again at every start edge, small differences in frequency and phase between the two ends are absorbed frame by frame.

When the stop-bit sample is high, the byte is presented with a one-clock valid pulse. When it is low, the frame is dropped. The receiver can detect a new start edge from the clock after the stop-bit sample, so frames sent with no idle gap between them are all received.

Top module: `uart_rx_os16`

## Requirements
- R1: While reset is high, and in the first clock after it is released, `byte_valid_o` is 0 and `byte_o` is 0x00.
- R2: In idle, a high-to-low transition of the synchronised line starts a frame. If the line is high at the 8th oversample pulse after that transition, the event is a glitch: the receiver returns to idle, produces no strobe, and still accepts the next genuine start edge.
- R3: Data bit n (n = 0..7) is sampled at oversample pulse 24 + 16·n counted from the start edge, and is placed in `byte_o[n]`, so the first bit on the line is the least significant bit.
- R4: The stop bit is sampled at pulse 152. If it is high, `byte_valid_o` is 1 for exactly the one clock that follows that pulse, and `byte_o` holds the received byte in that clock.
- R5: If the stop-bit sample is low, no strobe is produced and `byte_o` keeps the last correctly framed byte.
- R6: Frames sent back to back, where each start bit directly follows the previous stop bit, are all received in order.
- R7: A sender whose bit period differs from 16 pulses by about 2% in either direction is still received correctly.
- R8: `byte_o` changes only in a clock where `byte_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| os_tick_i | input | 1 | One-clock strobe at 16x the bit rate |
| byte_valid_o | output | 1 | One-clock pulse when a good frame ends |
| byte_o | output | 8 | Last correctly received byte |

## Verification
The bench sends a short low pulse that ends before the start-bit midpoint. A receiver that skips the midpoint check would treat this pulse as a start bit and report a phantom byte, or it would fail to recognise the real frame that follows. Frames are also sent back to back, and in some runs the bit period is stretched or shortened by about 2%. A receiver that is not ready right after the stop sample, or that counts the wrong number of pulses between samples, would lose bytes or shift their bits. A frame with its stop bit held low must change nothing at the outputs. Finally, a cycle-level model checks when each strobe occurs, so a strobe that comes a clock early or late is caught.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Frame walker states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Per-cycle control flags passed from the frame walker to the datapath
    typedef struct packed {
        logic take_bit;   // shift the current line value into the word
        logic frame_ok;   // stop sample was high: publish the word
    } rx_ctl_t;

    localparam int unsigned OS_RATE_DEFAULT = 16;

    // Integer divisor of the system clock that yields the oversample strobe
    function automatic int unsigned os_divisor(input int unsigned clk_hz,
                                               input int unsigned bit_rate,
                                               input int unsigned os_rate);
        return clk_hz / (bit_rate * os_rate);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rx_i,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q[0] <= 1'b1;
        else       chain_q[0] <= rx_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[g] <= 1'b1;
            else       chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b1;
        else       prev_q <= chain_q[STAGES-1];
    end

    assign line_o = chain_q[STAGES-1];
    assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned OS_RATE   = 16
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    tick_i,
    input  logic    line_i,
    input  logic    fall_i,
    output rx_ctl_t ctl_o
);
    localparam int unsigned CNT_W   = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
    localparam int unsigned IDX_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        state_d        = state_q;
        cnt_d          = cnt_q;
        idx_d          = idx_q;
        ctl_o.take_bit = 1'b0;
        ctl_o.frame_ok = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (fall_i) begin
                    state_d = RX_START;
                    cnt_d   = '0;
                end
            end
            RX_START: begin
                if (tick_i) begin
                    if (cnt_q == MID_CNT) begin
                        cnt_d   = '0;
                        idx_d   = '0;
                        state_d = line_i ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick_i) begin
                    if (cnt_q == LAST_CNT) begin
                        cnt_d          = '0;
                        ctl_o.take_bit = 1'b1;
                        if (idx_q == LAST_IDX) state_d = RX_STOP;
                        else                   idx_d   = idx_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick_i) begin
                    if (cnt_q == LAST_CNT) begin
                        cnt_d          = '0;
                        ctl_o.frame_ok = line_i;
                        state_d        = RX_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

endmodule

// File: rtl/rx_bit_shift.sv
module rx_bit_shift #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             take_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_o
);
    logic [WIDTH-1:0] word_q;

    // First bit received ends up in bit 0 after WIDTH shifts
    always_ff @(posedge clk_i) begin
        if (rst_i)       word_q <= '0;
        else if (take_i) word_q <= {bit_i, word_q[WIDTH-1:1]};
    end

    assign word_o = word_q;

endmodule

// File: rtl/uart_rx_os16.sv
module uart_rx_os16
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_BITS   = 8,
    parameter int unsigned OS_RATE     = OS_RATE_DEFAULT,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 rx_i,
    input  logic                 os_tick_i,
    output logic                 byte_valid_o,
    output logic [DATA_BITS-1:0] byte_o
);
    logic                 line_s;
    logic                 fall_s;
    rx_ctl_t              ctl_s;
    logic [DATA_BITS-1:0] word_s;
    logic                 valid_q;
    logic [DATA_BITS-1:0] byte_q;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .rx_i   (rx_i),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    rx_frame_ctl #(.DATA_BITS(DATA_BITS), .OS_RATE(OS_RATE)) u_ctl (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (os_tick_i),
        .line_i (line_s),
        .fall_i (fall_s),
        .ctl_o  (ctl_s)
    );

    rx_bit_shift #(.WIDTH(DATA_BITS)) u_shift (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .take_i (ctl_s.take_bit),
        .bit_i  (line_s),
        .word_o (word_s)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            byte_q  <= '0;
        end else begin
            valid_q <= ctl_s.frame_ok;
            if (ctl_s.frame_ok) byte_q <= word_s;
        end
    end

    assign byte_valid_o = valid_q;
    assign byte_o       = byte_q;

endmodule

// File: rtl/uart_rx_os16_chk.sv
module uart_rx_os16_chk #(
    parameter int unsigned DATA_BITS = 8
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 os_tick_i,
    input logic                 line_s,
    input logic                 byte_valid_o,
    input logic [DATA_BITS-1:0] byte_o
);
    // R1: reset clears the strobe and byte
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (!byte_valid_o && byte_o == '0));

    // R4: strobe lasts a single clock
    p_single_strobe_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_valid_o |=> !byte_valid_o);

    // R4: strobe follows an oversample pulse with the line high
    p_strobe_after_tick_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_valid_o |-> ($past(os_tick_i) && $past(line_s)));

    // R8: byte held between strobes
    p_byte_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !byte_valid_o |-> $stable(byte_o));

endmodule

bind uart_rx_os16 uart_rx_os16_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .os_tick_i    (os_tick_i),
    .line_s       (line_s),
    .byte_valid_o (byte_valid_o),
    .byte_o       (byte_o)
);

// File: tb/sim_uart_rx_os16.sv
module sim_uart_rx_os16;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;
    localparam int NOM_BIT    = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx  = 1'b1;
    logic       tick = 1'b0;
    logic       valid;
    logic [7:0] dout;

    int checks = 0;
    int fails  = 0;
    int tcnt   = 0;
    int strobes = 0;
    logic [7:0] rx_seen[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_os16 u0 (
        .clk_i        (clk),
        .rst_i        (rst),
        .rx_i         (rx),
        .os_tick_i    (tick),
        .byte_valid_o (valid),
        .byte_o       (dout)
    );

    // Oversample strobe: one clock high every TICK_DIV clocks
    always @(negedge clk) begin
        tcnt <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
        tick <= (tcnt == 0);
    end

    // Reference model: counts pulses since the start edge
    logic       m_s1 = 1'b1, m_s2 = 1'b1, m_prev = 1'b1;
    bit         m_busy = 0;
    int         m_ticks = 0;
    logic [7:0] m_byte = 8'h00;
    logic       exp_valid = 1'b0;
    logic [7:0] exp_data = 8'h00;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1;
            m_busy = 0; exp_valid = 1'b0; exp_data = 8'h00;
        end else begin
            exp_valid = 1'b0;
            if (!m_busy) begin
                if (m_prev && !m_s2) begin
                    m_busy = 1; m_ticks = 0;
                end
            end else if (tick) begin
                m_ticks++;
                if (m_ticks == 8) begin
                    if (m_s2) m_busy = 0;
                end else if (m_ticks > 8 && (m_ticks - 8) % 16 == 0) begin
                    int k;
                    k = (m_ticks - 8) / 16;
                    if (k <= 8) m_byte[k-1] = m_s2;
                    else begin
                        if (m_s2) begin
                            exp_valid = 1'b1;
                            exp_data  = m_byte;
                        end
                        m_busy = 0;
                    end
                end
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = rx;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R4 timing, R3 content)
    always @(negedge clk) begin
        if (!rst) begin
            check(valid == exp_valid, "R4 strobe timing", valid, exp_valid);
            check(dout == exp_data, "R3 byte value", dout, exp_data);
            if (valid) begin
                strobes++;
                rx_seen.push_back(dout);
            end
        end
    end

    task automatic hold_line(input logic v, input int clks);
        for (int i = 0; i < clks; i++) begin
            rx <= v;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop, input int bit_clks);
        hold_line(1'b0, bit_clks);
        for (int i = 0; i < 8; i++) hold_line(b[i], bit_clks);
        hold_line(stop, bit_clks);
    endtask

    task automatic expect_frames(input string req, input logic [7:0] exp_q[$]);
        check(rx_seen.size() == exp_q.size(), req, rx_seen.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_seen.size(); i++)
            check(rx_seen[i] == exp_q[i], req, rx_seen[i], exp_q[i]);
        rx_seen.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(valid == 1'b0, "R1 valid in reset", valid, 0);
        check(dout == 8'h00, "R1 byte in reset", dout, 0);
        rst <= 1'b0;
        @(negedge clk);
        check(valid == 1'b0 && dout == 8'h00, "R1 after release", dout, 0);
        hold_line(1'b1, 100);

        // R3 / R4: nominal frames with varied patterns
        send_frame(8'hA5, 1'b1, NOM_BIT); hold_line(1'b1, 60);
        send_frame(8'h01, 1'b1, NOM_BIT); hold_line(1'b1, 60);
        send_frame(8'h80, 1'b1, NOM_BIT); hold_line(1'b1, 60);
        send_frame(8'hFF, 1'b1, NOM_BIT); hold_line(1'b1, 60);
        send_frame(8'h00, 1'b1, NOM_BIT); hold_line(1'b1, 60);
        expect_frames("R3 LSB-first bytes", '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00});

        // R5: bad stop bit dropped, byte held
        send_frame(8'h3C, 1'b0, NOM_BIT); hold_line(1'b1, 100);
        expect_frames("R5 bad stop dropped", '{});
        check(dout == 8'h00, "R5 byte held", dout, 8'h00);

        // R2: short glitch, then a genuine frame
        hold_line(1'b0, 2 * TICK_DIV);
        hold_line(1'b1, 600);
        expect_frames("R2 glitch ignored", '{});
        check(dout == 8'h00, "R2 byte unchanged by glitch", dout, 8'h00);
        send_frame(8'h5A, 1'b1, NOM_BIT); hold_line(1'b1, 60);
        expect_frames("R2 recovery frame", '{8'h5A});

        // R6: back-to-back frames
        send_frame(8'h11, 1'b1, NOM_BIT);
        send_frame(8'h22, 1'b1, NOM_BIT);
        send_frame(8'h33, 1'b1, NOM_BIT);
        hold_line(1'b1, 60);
        expect_frames("R6 back-to-back", '{8'h11, 8'h22, 8'h33});

        // R7: sender about 2% fast and slow
        send_frame(8'hC3, 1'b1, NOM_BIT - 1); hold_line(1'b1, 60);
        send_frame(8'h96, 1'b1, NOM_BIT + 1); hold_line(1'b1, 60);
        send_frame(8'h69, 1'b1, NOM_BIT - 1);
        send_frame(8'h4B, 1'b1, NOM_BIT - 1);
        hold_line(1'b1, 60);
        expect_frames("R7 rate mismatch", '{8'hC3, 8'h96, 8'h69, 8'h4B});

        // R8: long idle, byte stays put
        hold_line(1'b1, 300);
        check(dout == 8'h4B, "R8 byte stable in idle", dout, 8'h4B);
        check(strobes == 13, "R4 total strobes", strobes, 13);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule